// File: doc/BRIEF.md
# Reversible Nibble Counter with Cascade Pulse

This block is a binary counter whose width is set by a parameter (four bits by default). It counts up or down by one on each rising clock edge while its active-low enable is asserted. An active-low load input forces the count to an external value at any moment, without waiting for the clock, and overrides every other input.

Two outputs support chaining several counters. A terminal flag rises whenever the count sits at the last value for the chosen direction: all ones when counting up, zero when counting down. An active-low cascade pulse copies the low half of the clock whenever the stage is enabled and at its terminal value. A following stage can use that pulse as its clock, or as a borrow/carry signal.

Top module: `nibctr_top`

## Requirements
- R1: With `load_n` high, `cnt_en_n` low and `dir_down` low, every rising clock edge adds one to `q` modulo 2^WIDTH, so 15 is followed by 0.
- R2: With `load_n` high, `cnt_en_n` low and `dir_down` high, every rising clock edge subtracts one from `q` modulo 2^WIDTH, so 0 is followed by 15.
- R3: With `load_n` high and `cnt_en_n` high, `q` keeps its value across clock edges.
- R4: While `load_n` is low, `q` equals `din` with no clock edge needed, whatever `cnt_en_n` and the clock do. After `load_n` returns high, counting resumes from the loaded value.
- R5: `term` is 1 exactly when `dir_down` is 0 and `q` is all ones, or when `dir_down` is 1 and `q` is 0. It follows a change of `dir_down` without waiting for a clock edge.
- R6: `term` does not depend on `cnt_en_n`.
- R7: `ripple_n` is 0 exactly while `cnt_en_n` is 0, `term` is 1 and `clk` is 0.
- R8: `ripple_n` is 1 throughout every high phase of `clk`.
- R9: While `cnt_en_n` is 1, `ripple_n` stays 1 even at terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge active |
| load_n | input | 1 | Asynchronous load, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| din | input | WIDTH | Value to load |
| q | output | WIDTH | Current count |
| term | output | 1 | Terminal count flag |
| ripple_n | output | 1 | Active-low cascade pulse |

## Verification
The clocked assertions assume that `load_n` does not pulse low and return high between two rising edges. They also assume that `din` is stable whenever `load_n` rises. A load that starts between edges must still be low at the next edge, so the checks are switched off there. The bench asserts `load_n` at a falling edge and holds it through at least one rising edge. It keeps `din` unchanged for at least one edge before releasing the load. All other inputs change only in the middle of the low clock phase.

// File: rtl/nibctr_pkg.sv
package nibctr_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2
    } op_e;
endpackage

// File: rtl/nibctr_next.sv
module nibctr_next #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             cnt_en_n,
    input  logic             dir_down,
    output logic [WIDTH-1:0] nxt
);
    import nibctr_pkg::*;

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    op_e op;

    always_comb begin
        if (cnt_en_n)
            op = OP_HOLD;
        else if (dir_e'(dir_down) == DIR_DOWN)
            op = OP_DEC;
        else
            op = OP_INC;
    end

    // Natural wrap of WIDTH-bit arithmetic gives modulo behaviour.
    always_comb begin
        unique case (op)
            OP_INC:  nxt = cur + ONE;
            OP_DEC:  nxt = cur - ONE;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/nibctr_term.sv
module nibctr_term #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             dir_down,
    output logic             term
);
    localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] BOT_VAL = '0;

    logic at_top;
    logic at_bot;

    assign at_top = (cur == TOP_VAL);
    assign at_bot = (cur == BOT_VAL);

    // Purely combinational on count and direction; enable is not an input.
    assign term = dir_down ? at_bot : at_top;
endmodule

// File: rtl/nibctr_ripple.sv
module nibctr_ripple (
    input  logic clk,
    input  logic cnt_en_n,
    input  logic term,
    output logic ripple_n
);
    logic fire;

    assign fire     = ~cnt_en_n & term;
    assign ripple_n = ~(fire & ~clk);
endmodule

// File: rtl/nibctr_top.sv
module nibctr_top #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             dir_down,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             term,
    output logic             ripple_n
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } state_t;

    state_t           st_d, st_q;
    logic [WIDTH-1:0] nxt_cnt;

    nibctr_next #(.WIDTH(WIDTH)) u_next (
        .cur      (st_q.cnt),
        .cnt_en_n (cnt_en_n),
        .dir_down (dir_down),
        .nxt      (nxt_cnt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = nxt_cnt;
    end

    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n)
            st_q.cnt <= din;
        else
            st_q <= st_d;
    end

    // Transparent while loading so q tracks din without a clock.
    assign q = load_n ? st_q.cnt : din;

    nibctr_term #(.WIDTH(WIDTH)) u_term (
        .cur      (q),
        .dir_down (dir_down),
        .term     (term)
    );

    nibctr_ripple u_ripple (
        .clk      (clk),
        .cnt_en_n (cnt_en_n),
        .term     (term),
        .ripple_n (ripple_n)
    );

    // R1
    up_step_chk: assert property (@(posedge clk) disable iff (!load_n)
        (!cnt_en_n && !dir_down) |=> (q == WIDTH'($past(q) + 1'b1)));

    // R2
    down_step_chk: assert property (@(posedge clk) disable iff (!load_n)
        (!cnt_en_n && dir_down) |=> (q == WIDTH'($past(q) - 1'b1)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!load_n)
        cnt_en_n |=> $stable(q));

    // R6
    term_stable_chk: assert property (@(posedge clk) disable iff (!load_n)
        ($stable(q) && $stable(dir_down)) |-> $stable(term));

    // R8
    ripple_high_phase_chk: assert property (@(negedge clk) disable iff (!load_n)
        ripple_n);
endmodule

// File: tb/tb_nibctr_top.sv
`timescale 1ns/100ps
module tb_nibctr_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         load_n = 1'b0;
    logic         cnt_en_n = 1'b1;
    logic         dir_down = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;
    logic         term;
    logic         ripple_n;

    int checks = 0;
    int failures = 0;
    int ref_q = 0;
    bit done = 1'b0;

    nibctr_top #(.WIDTH(W)) dut (
        .clk(clk), .load_n(load_n), .cnt_en_n(cnt_en_n), .dir_down(dir_down),
        .din(din), .q(q), .term(term), .ripple_n(ripple_n)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_term(input int v, input logic dn);
        return dn ? int'(v == 0) : int'(v == 15);
    endfunction

    // One clock period: inputs set in the low phase, both phases checked.
    task automatic step(input logic en_n, input logic dn, input string req);
        @(negedge clk);
        #0.2;
        cnt_en_n = en_n;
        dir_down = dn;
        #0.8;
        chk({req, " q low phase"}, int'(q), ref_q);
        chk("R5 term", int'(term), exp_term(ref_q, dn));
        chk("R7 ripple low phase", int'(ripple_n),
            (!en_n && exp_term(ref_q, dn) == 1) ? 0 : 1);
        @(posedge clk);
        #0.5;
        if (!en_n) ref_q = dn ? (ref_q + 15) % 16 : (ref_q + 1) % 16;
        chk({req, " q after edge"}, int'(q), ref_q);
        chk("R8 ripple high phase", int'(ripple_n), 1);
    endtask

    task automatic do_load(input int v);
        @(negedge clk);
        #0.5;
        cnt_en_n = 1'b0;
        din = W'(v);
        load_n = 1'b0;
        #0.2;
        chk("R4 immediate load", int'(q), v);
        @(posedge clk);
        #0.5;
        chk("R4 load overrides count", int'(q), v);
        load_n = 1'b1;
        ref_q = v;
        #0.2;
        chk("R4 value kept after release", int'(q), v);
    endtask

    task automatic t_reset_state;
        #1;
        chk("R4 initial load value", int'(q), 0);
        chk("R5 initial term", int'(term), 0);
        chk("R9 initial ripple", int'(ripple_n), 1);
        @(posedge clk);
        #0.5;
        load_n = 1'b1;
        ref_q = 0;
    endtask

    task automatic t_count_up_wrap;
        do_load(13);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R1");
        chk("R1 wrap to 2", int'(q), 2);
    endtask

    task automatic t_count_down_wrap;
        do_load(2);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R2");
        chk("R2 wrap to 13", int'(q), 13);
    endtask

    task automatic t_hold_and_suppress;
        do_load(15);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R3");
        @(negedge clk);
        #1;
        chk("R6 term with enable off", int'(term), 1);
        chk("R9 ripple suppressed", int'(ripple_n), 1);
        cnt_en_n = 1'b0;
        #0.2;
        chk("R6 term with enable on", int'(term), 1);
        chk("R7 ripple asserted", int'(ripple_n), 0);
        cnt_en_n = 1'b1;
        #0.2;
        chk("R9 ripple released by enable", int'(ripple_n), 1);
    endtask

    task automatic t_dir_change_at_terminal;
        do_load(15);
        @(negedge clk);
        #0.5;
        cnt_en_n = 1'b1;
        dir_down = 1'b0;
        #0.2;
        chk("R5 term up at 15", int'(term), 1);
        dir_down = 1'b1;
        #0.2;
        chk("R5 term drops on direction change", int'(term), 0);
        step(1'b0, 1'b1, "R2");
        chk("R2 down from 15", int'(q), 14);
    endtask

    task automatic t_load_during_count;
        do_load(5);
        step(1'b0, 1'b0, "R1");
        @(negedge clk);
        #0.5;
        din = 4'd9;
        load_n = 1'b0;
        #0.2;
        chk("R4 load mid count", int'(q), 9);
        din = 4'd0;
        #0.2;
        chk("R4 tracks din while low", int'(q), 0);
        dir_down = 1'b1;
        #0.2;
        chk("R5 term during load", int'(term), 1);
        chk("R7 ripple during load", int'(ripple_n), 0);
        @(posedge clk);
        #0.5;
        chk("R4 clock ignored in load", int'(q), 0);
        load_n = 1'b1;
        ref_q = 0;
        step(1'b0, 1'b1, "R2");
        chk("R4 resume from loaded", int'(q), 15);
    endtask

    initial begin
        t_reset_state();
        t_count_up_wrap();
        t_count_down_wrap();
        t_hold_and_suppress();
        t_dir_change_at_terminal();
        t_load_during_count();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule